// File: doc/BRIEF.md
# Auto-Acknowledging Priority Interrupt Controller

This block collects a parameterised set of level-sensitive interrupt lines and presents them to a small group of processors through a 32-bit register bus. Each line carries a mask bit and a software trigger bit. A line counts as pending when its hardware input or its software bit is high. A per-line routing register names the processors that may take the line. Each processor also gets a request output, which is high while at least one line is ready for it.

A processor claims work by reading one event register. The `cpu_id` input selects which processor's view the read uses. The read returns the lowest-numbered line that is pending, unmasked and routed to that processor. In the same clock edge the controller sets that line's mask bit, so the line cannot be delivered again. Software finishes handling the line by clearing its mask bit. Line index alone fixes priority.

A two-state bus sequencer sets the read timing. In ST_IDLE no response is on the bus. A read moves it to ST_RESP (transition IDLE_TO_RESP). A further read in the next cycle keeps it in ST_RESP (transition RESP_HOLD). A cycle with no read returns it to ST_IDLE (transition RESP_TO_IDLE). With no read it stays in ST_IDLE (transition IDLE_HOLD). Writes take effect in either state.

Top module: `ic_autoack_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every software bit is 0, and every routing register holds 1 (processor 0 only). In this state `bus_rvalid` and `irq_out` are 0 and an event read returns 0.
- R2: A read of byte address 0x000 returns the number of implemented lines in bits [15:0], with bits [31:16] at 0.
- R3: Line n sits in word n>>5, bit n&31. A write of ones to 0x100+4w sets software bits in that word, and a write of ones to 0x180+4w clears them. A read of either address returns the software bits. The pending state of a line is its hardware input OR its software bit.
- R4: A write of ones to 0x200+4w sets mask bits, and a write of ones to 0x280+4w clears them. A read of either address returns the mask word.
- R5: A read of 0x300+4w returns the raw hardware input levels of that word. Writes to this address change nothing.
- R6: A read of the event register at 0x004 returns {8'h00, 8'h01, 16-bit line} for the lowest-numbered line that is pending, unmasked and routed to `cpu_id`. It returns 0 when no line qualifies. Hardware levels present in the read cycle count.
- R7: An event read that returns a line sets that line's mask bit at the same edge, so the next event read returns the next qualifying line.
- R8: The routing register of line n at 0x1000+4n holds a processor bitmask in its low NCPU bits and reads back zero-extended. Only processors whose bit is set can claim the line.
- R9: `irq_out[c]` is 1 exactly when some line is pending, unmasked and routed to processor c.
- R10: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. `bus_rvalid` is 0 in any cycle that does not follow a read.
- R11: When `bus_rd` and `bus_wr` are both high for the same register, the read returns the contents before the write, and the write takes effect for later reads.
- R12: Reads of addresses outside the map, or with bits [1:0] not zero, return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NLINES | Level-sensitive hardware interrupt lines |
| cpu_id | input | CW | Processor whose view the current access uses |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd |
| irq_out | output | NCPU | Per-processor request: some line ready for it |

## Verification
Two pairs of actions can fall in the same cycle. The first pair is a read and a write aimed at the same mask word. The bench raises `bus_rd` and `bus_wr` together on the mask-clear address. It expects the old all-ones word back, and then the cleared bit on a plain read that follows. The second pair is a hardware line rising in the very cycle of an event read. The bench raises a higher-priority line together with the read strobe and expects that line to beat an older software-pending line. The older line must follow on the next read.

// File: rtl/ic_pkg.sv
`timescale 1ns/1ps
package ic_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_RESP} bus_st_e;

    localparam logic [7:0] EVT_KIND_HW = 8'h01;

    // Word offsets (byte offset / 4). Line-vector regions are 32-word aligned.
    localparam int unsigned WOFS_INFO  = 'h000;
    localparam int unsigned WOFS_EVENT = 'h001;
    localparam int unsigned WOFS_SWSET = 'h040;
    localparam int unsigned WOFS_SWCLR = 'h060;
    localparam int unsigned WOFS_MSET  = 'h080;
    localparam int unsigned WOFS_MCLR  = 'h0A0;
    localparam int unsigned WOFS_HWIN  = 'h0C0;
    localparam int unsigned WOFS_ROUTE = 'h400;

    function automatic logic [31:0] pack_event(input logic [15:0] line);
        return {8'h00, EVT_KIND_HW, line};
    endfunction
endpackage

// File: rtl/ic_prio_enc.sv
`timescale 1ns/1ps
module ic_prio_enc #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ic_line_regs.sv
`timescale 1ns/1ps
module ic_line_regs #(
    parameter int NLINES = 64,
    parameter int NCPU   = 4,
    parameter int IW     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sws_we,
    input  logic                   swc_we,
    input  logic                   ms_we,
    input  logic                   mc_we,
    input  logic                   rt_we,
    input  logic [4:0]             wsel,
    input  logic [IW-1:0]          rt_sel,
    input  logic [31:0]            wdata,
    input  logic                   claim,
    input  logic [IW-1:0]          claim_idx,
    output logic [NLINES-1:0]      mask_q,
    output logic [NLINES-1:0]      sw_q,
    output logic [NLINES*NCPU-1:0] route_q
);
    logic [NLINES-1:0]      mask_d, sw_d;
    logic [NLINES*NCPU-1:0] route_d;

    always_comb begin
        mask_d  = mask_q;
        sw_d    = sw_q;
        route_d = route_q;
        for (int n = 0; n < NLINES; n++) begin
            if (wsel == 5'(n / 32) && wdata[n % 32]) begin
                if (ms_we)  mask_d[n] = 1'b1;
                if (mc_we)  mask_d[n] = 1'b0;
                if (sws_we) sw_d[n]   = 1'b1;
                if (swc_we) sw_d[n]   = 1'b0;
            end
            if (rt_we && rt_sel == IW'(n))
                route_d[n*NCPU +: NCPU] = wdata[NCPU-1:0];
        end
        // auto-mask of the claimed line is applied last
        if (claim) mask_d[claim_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            sw_q   <= '0;
            for (int n = 0; n < NLINES; n++)
                route_q[n*NCPU +: NCPU] <= NCPU'(1);
        end else begin
            mask_q  <= mask_d;
            sw_q    <= sw_d;
            route_q <= route_d;
        end
    end
endmodule

// File: rtl/ic_autoack_ctrl.sv
`timescale 1ns/1ps
module ic_autoack_ctrl #(
    parameter int NLINES = 64,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 14,
    parameter int CW     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] hw_irq,
    input  logic [CW-1:0]     cpu_id,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [NCPU-1:0]   irq_out
);
    import ic_pkg::*;

    localparam int IW     = $clog2(NLINES);
    localparam int NWORDS = (NLINES + 31) / 32;
    localparam int WAW    = ADDR_W - 2;
    localparam logic [WAW-1:0] A_INFO   = WAW'(WOFS_INFO);
    localparam logic [WAW-1:0] A_EVT    = WAW'(WOFS_EVENT);
    localparam logic [WAW-1:0] A_SWS    = WAW'(WOFS_SWSET);
    localparam logic [WAW-1:0] A_SWC    = WAW'(WOFS_SWCLR);
    localparam logic [WAW-1:0] A_MS     = WAW'(WOFS_MSET);
    localparam logic [WAW-1:0] A_MC     = WAW'(WOFS_MCLR);
    localparam logic [WAW-1:0] A_HW     = WAW'(WOFS_HWIN);
    localparam logic [WAW-1:0] A_RT     = WAW'(WOFS_ROUTE);
    localparam logic [WAW-1:0] SPAN_W   = WAW'(NWORDS);
    localparam logic [WAW-1:0] SPAN_RT  = WAW'(NLINES);

    // ---------------- address decode ----------------
    logic [WAW-1:0] word;
    logic           aligned;
    logic in_info, in_evt, in_sws, in_swc, in_ms, in_mc, in_hw, in_rt;
    logic [4:0]     wsel;
    logic [IW-1:0]  rt_sel;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign in_info = aligned && word == A_INFO;
    assign in_evt  = aligned && word == A_EVT;
    assign in_sws  = aligned && word >= A_SWS && word < A_SWS + SPAN_W;
    assign in_swc  = aligned && word >= A_SWC && word < A_SWC + SPAN_W;
    assign in_ms   = aligned && word >= A_MS  && word < A_MS  + SPAN_W;
    assign in_mc   = aligned && word >= A_MC  && word < A_MC  + SPAN_W;
    assign in_hw   = aligned && word >= A_HW  && word < A_HW  + SPAN_W;
    assign in_rt   = aligned && word >= A_RT  && word < A_RT  + SPAN_RT;
    assign wsel    = word[4:0];
    assign rt_sel  = IW'(word - A_RT);

    // ---------------- line state ----------------
    logic [NLINES-1:0]      mask_q, sw_q, pend, route_sel, elig_sel;
    logic [NLINES*NCPU-1:0] route_q;
    logic                   hit, claim;
    logic [IW-1:0]          win_idx;

    ic_line_regs #(.NLINES(NLINES), .NCPU(NCPU), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sws_we(bus_wr && in_sws), .swc_we(bus_wr && in_swc),
        .ms_we(bus_wr && in_ms),   .mc_we(bus_wr && in_mc),
        .rt_we(bus_wr && in_rt),
        .wsel(wsel), .rt_sel(rt_sel), .wdata(bus_wdata),
        .claim(claim), .claim_idx(win_idx),
        .mask_q(mask_q), .sw_q(sw_q), .route_q(route_q)
    );

    assign pend = hw_irq | sw_q;

    always_comb begin
        for (int n = 0; n < NLINES; n++)
            route_sel[n] = (int'(cpu_id) < NCPU) ? route_q[n*NCPU + int'(cpu_id)] : 1'b0;
    end
    assign elig_sel = pend & ~mask_q & route_sel;

    ic_prio_enc #(.N(NLINES), .IW(IW)) u_enc (
        .req(elig_sel), .hit(hit), .idx(win_idx)
    );

    assign claim = bus_rd && in_evt && hit;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu_req
        logic [NLINES-1:0] col;
        for (genvar n = 0; n < NLINES; n++) begin : g_col
            assign col[n] = route_q[n*NCPU + c];
        end
        assign irq_out[c] = |(pend & ~mask_q & col);
    end

    // ---------------- read data ----------------
    function automatic logic [31:0] pick_word(input logic [NLINES-1:0] v, input logic [4:0] w);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < 32; j++) begin
            if (int'(w) * 32 + j < NLINES) r[j] = v[int'(w) * 32 + j];
        end
        return r;
    endfunction

    logic [31:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (in_info)               rd_mux = {16'h0000, 16'(NLINES)};
        else if (in_evt)           rd_mux = hit ? pack_event(16'(win_idx)) : 32'h0;
        else if (in_sws || in_swc) rd_mux = pick_word(sw_q, wsel);
        else if (in_ms || in_mc)   rd_mux = pick_word(mask_q, wsel);
        else if (in_hw)            rd_mux = pick_word(hw_irq, wsel);
        else if (in_rt) begin
            for (int n = 0; n < NLINES; n++)
                if (rt_sel == IW'(n)) rd_mux = 32'(route_q[n*NCPU +: NCPU]);
        end
    end

    // ---------------- bus sequencer ----------------
    bus_st_e state_q, state_d;
    logic [31:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = bus_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = bus_rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    always_comb begin
        bus_rvalid = (state_q == ST_RESP);
        bus_rdata  = rdata_q;
    end
endmodule

// File: rtl/ic_autoack_chk.sv
`timescale 1ns/1ps
module ic_autoack_chk #(
    parameter int NLINES = 64,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 14,
    parameter int CW     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [CW-1:0]     cpu_id,
    input logic [NCPU-1:0]   irq_out,
    input logic [NLINES-1:0] mask_q
);
    localparam int IW = $clog2(NLINES);

    logic evt_rd, info_rd, irq_sel;
    assign evt_rd  = bus_rd && bus_addr == ADDR_W'(4);
    assign info_rd = bus_rd && bus_addr == ADDR_W'(0);
    assign irq_sel = (int'(cpu_id) < NCPU) ? irq_out[cpu_id] : 1'b0;

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R10
    AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R10
    AST_INFO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        info_rd |=> bus_rdata == 32'(NLINES)); // R2
    AST_EVENT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (bus_rdata == 32'h0 || bus_rdata[31:16] == 16'h0001)); // R6
    AST_EVENT_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && irq_sel) |=> bus_rdata != 32'h0); // R6
    AST_EVENT_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && !irq_sel) |=> bus_rdata == 32'h0); // R9
    AST_CLAIM_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (bus_rdata == 32'h0 ||
                    (32'(bus_rdata[15:0]) < NLINES && mask_q[bus_rdata[IW-1:0]]))); // R7
endmodule

bind ic_autoack_ctrl ic_autoack_chk #(
    .NLINES(NLINES), .NCPU(NCPU), .ADDR_W(ADDR_W), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_id(cpu_id),
    .irq_out(irq_out), .mask_q(mask_q)
);

// File: tb/tb_ic_autoack_ctrl.sv
`timescale 1ns/1ps
module tb_ic_autoack_ctrl;
    localparam int NL = 64, NC = 4, AW = 14, CW = 2;
    localparam logic [AW-1:0] A_INFO = 'h000, A_EVT = 'h004, A_SWS = 'h100, A_SWC = 'h180,
                              A_MS = 'h200, A_MC = 'h280, A_HW = 'h300, A_RT = 'h1000;

    logic clk = 0, rst_n = 0;
    logic [NL-1:0] hw_irq = '0;
    logic [CW-1:0] cpu_id = '0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_rvalid;
    logic [NC-1:0] irq_out;

    ic_autoack_ctrl #(.NLINES(NL), .NCPU(NC), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .cpu_id(cpu_id),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R10: actual unexpected response %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rdwr(input logic [AW-1:0] a, input logic [31:0] d, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 1;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 rvalid after reset", 32'(bus_rvalid), 32'h0);
        check("R1 irq_out after reset", 32'(irq_out), 32'h0);
        rd(A_MS, 32'hFFFF_FFFF, "R1 mask word0 reset");
        rd(A_MC + 4, 32'hFFFF_FFFF, "R1 mask word1 reset");
        rd(A_SWS, 32'h0, "R1 sw word0 reset");
        rd(A_RT + 4*5, 32'h1, "R1 route line5 reset");
        rd(A_EVT, 32'h0, "R1 event empty after reset");
        rd(A_INFO, 32'd64, "R2 info line count");
        rd('h0800, 32'h0, "R12 unmapped read");
        rd(A_MS + 1, 32'h0, "R12 misaligned read");

        // hardware line 40 (word1 bit8)
        hw_irq[40] = 1'b1;
        rd(A_HW + 4, 32'h0000_0100, "R5 raw input word1");
        wr(A_HW + 4, 32'hFFFF_FFFF);
        rd(A_HW + 4, 32'h0000_0100, "R5 write to raw input ignored");
        rd(A_EVT, 32'h0, "R6 masked line not delivered");
        wr(A_MC + 4, 32'h0000_0100);
        rd(A_MS + 4, 32'hFFFF_FEFF, "R4 mask clear word1");
        check("R9 irq_out line40 cpu0", 32'(irq_out), 32'h1);
        rd(A_EVT, 32'h0001_0028, "R6 event returns line 40");
        rd(A_MS + 4, 32'hFFFF_FFFF, "R7 line 40 masked by claim");
        check("R9 irq_out drops after claim", 32'(irq_out), 32'h0);
        wr('h0804, 32'hFFFF_FFFF);
        rd(A_MS + 4, 32'hFFFF_FFFF, "R12 unmapped write ignored");

        // software triggers on lines 3 and 7
        wr(A_SWS, 32'h0000_0088);
        rd(A_SWS, 32'h0000_0088, "R3 software set word0");
        wr(A_MC, 32'h0000_0088);
        rd(A_EVT, 32'h0001_0003, "R6 lowest index first");
        rd(A_EVT, 32'h0001_0007, "R7 next line after auto-mask");
        rd(A_EVT, 32'h0, "R7 nothing left");
        wr(A_SWC, 32'h0000_0008);
        rd(A_SWC, 32'h0000_0080, "R3 software clear word0");
        wr(A_MS, 32'h0000_0001);
        rd(A_MC, 32'hFFFF_FFFF, "R4 mask set word0");

        // routing line 7 to cpu1
        wr(A_RT + 4*7, 32'h0000_0002);
        rd(A_RT + 4*7, 32'h0000_0002, "R8 route readback");
        wr(A_MC, 32'h0000_0080);
        check("R9 irq_out routed to cpu1", 32'(irq_out), 32'h2);
        rd(A_EVT, 32'h0, "R8 cpu0 cannot claim line 7");
        cpu_id = 2'd1;
        rd(A_EVT, 32'h0001_0007, "R8 cpu1 claims line 7");
        cpu_id = 2'd0;

        // same-cycle read and write of one mask word
        rdwr(A_MC, 32'h0000_0004, 32'hFFFF_FFFF, "R11 read returns pre-write mask");
        rd(A_MS, 32'hFFFF_FFFB, "R11 write applied after collision");

        // hardware line rising in the event-read cycle
        wr(A_SWS, 32'h0000_0200);
        wr(A_MC, 32'h0000_0200);
        @(negedge clk);
        exp_q.push_back(32'h0001_0002); tag_q.push_back("R6 line rising in read cycle wins");
        hw_irq[2] = 1'b1; bus_addr = A_EVT; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        rd(A_EVT, 32'h0001_0009, "R6 older line follows");
        hw_irq[2] = 1'b0;
        rd(A_EVT, 32'h0, "R6 empty again");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R10: actual %0d responses missing expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule